// File: doc/BRIEF.md
# System Bus Address Decode Router

This block sits between a processor's system bus and the targets behind it. It takes one request at a time. Each request carries a 32-bit physical address, a read/write flag, an access size and a cached/uncached flag. The router sorts the address into main RAM, the internal register space, the external parallel bus using one of two timing configurations, a filler stub, or an ignored region. It reports the chosen target and timing configuration. After a latency that depends on the target, it raises a one-cycle completion pulse, with read data supplied by built-in stub responders.

Some requests are never answered, by design. These are addresses with bit 31 set, cached requests to anything other than RAM, and 64-bit reads from register space or the external bus. In these cases the router parks and gives no reply. It also raises a `hung` flag so a test can see the stall without waiting forever. Only a reset releases it. Register and external-bus accesses ignore the requested size.

Top module: `sysbus_router`

## Requirements
- R1: Addresses 0x00000000–0x03EFFFFF select RAM (tgtSel=1, domSel=0). Every size completes after RAM_LAT=4 cycles, the size codes being 0=8, 1=16, 2=32 and 3=64 bits. Read data is {~addr, addr}, and write responses carry zero data.
- R2: Addresses 0x03F00000–0x03FFFFFF select registers (tgtSel=2). A read returns a single aligned word {addr[31:2],2'b00} in bits 31:0 with zeros above, whatever size was asked. The fast group 0x03F00000–0x03F0FFFF completes after 2 cycles and the rest after 5.
- R3: Addresses 0x06000000–0x07FFFFFF, 0x10000000–0x1FBFFFFF and 0x1FD00000–0x7FFFFFFF select the external bus (tgtSel=3) with domSel=1. They complete after 6 cycles. A read returns open-bus data {addr[15:0], addr[15:0]} in bits 31:0.
- R4: Addresses 0x08000000–0x0FFFFFFF select the external bus (tgtSel=3) with the slow configuration domSel=2. They complete after 10 cycles.
- R5: Addresses 0x80000000–0xFFFFFFFF select the ignored region (tgtSel=5). The router never raises rspValid for them and sets hung=1.
- R6: A cached request to any target other than RAM gets no reply and sets hung. A cached RAM request completes normally.
- R7: A 64-bit read to register space or the external bus gets no reply and sets hung. A 64-bit write there completes normally.
- R8: Addresses 0x04000000–0x05FFFFFF and 0x1FC00000–0x1FCFFFFF select the stub (tgtSel=4, domSel=0). They complete after 2 cycles with zero data, and this includes 64-bit reads.
- R9: Only one request is ever outstanding. reqReady is low from the accepting edge until the completion cycle has passed. Once hung is set, reqReady and hung stay as they are until reset.
- R10: After reset, reqReady=1, rspValid=0, tgtSel=0, domSel=0 and hung=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Router idle; request accepted on this edge if valid |
| reqAddr | input | 32 | Physical address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0=8, 1=16, 2=32, 3=64 bits |
| reqCached | input | 1 | Cached (line) request |
| rspValid | output | 1 | One-cycle completion pulse |
| rspData | output | 64 | Read data, valid with rspValid, zero otherwise |
| tgtSel | output | 3 | Target of last accepted request (0 none, 1 RAM, 2 regs, 3 ext, 4 stub, 5 ignored) |
| domSel | output | 2 | Timing configuration (0 none, 1 domain one, 2 domain two) |
| hung | output | 1 | Router parked on a never-completing request |

## Verification
The hardest state to reach from the ports is a stall that is not caused by the address alone. A 64-bit read or a cached flag turns an otherwise normal register or external-bus access into a permanent hang. The bench drives these attribute combinations against valid addresses in each class. It then holds reqValid high for many cycles to confirm that there is no completion and no second acceptance, and applies a reset to recover before the next scenario.

// File: rtl/sysbus_pkg.sv
`timescale 1ns/1ps
package sysbus_pkg;
  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_RAM    = 3'd1,
    TGT_REG    = 3'd2,
    TGT_EXT    = 3'd3,
    TGT_STUB   = 3'd4,
    TGT_IGNORE = 3'd5
  } target_e;

  typedef enum logic [1:0] {
    DOM_NONE = 2'd0,
    DOM_ONE  = 2'd1,
    DOM_TWO  = 2'd2
  } domain_e;

  localparam logic [1:0] SIZE_64 = 2'd3;

  typedef struct packed {
    target_e tgt;
    domain_e dom;
    logic    neverDone;
  } decodeRes_t;

  typedef struct packed {
    logic load;   // capture a newly accepted request
    logic tick;   // advance the latency counter
  } ctrlStrobe_t;
endpackage

// File: rtl/sysbus_decode.sv
`timescale 1ns/1ps
module sysbus_decode
  import sysbus_pkg::*;
#(
  parameter int unsigned RAM_LAT      = 4,
  parameter int unsigned REG_LAT      = 5,
  parameter int unsigned REG_FAST_LAT = 2,
  parameter int unsigned DOM1_LAT     = 6,
  parameter int unsigned DOM2_LAT     = 10,
  parameter int unsigned STUB_LAT     = 2,
  parameter int unsigned CW           = 4
) (
  input  logic [31:0]  addr,
  input  logic         write,
  input  logic [1:0]   size,
  input  logic         cached,
  output decodeRes_t   res,
  output logic [CW-1:0] lat
);
  always_comb begin
    res.tgt = TGT_STUB;
    res.dom = DOM_NONE;
    lat     = CW'(STUB_LAT);
    if (addr[31]) begin
      res.tgt = TGT_IGNORE;
    end else if (addr < 32'h03F0_0000) begin
      res.tgt = TGT_RAM;
      lat     = CW'(RAM_LAT);
    end else if (addr < 32'h0400_0000) begin
      res.tgt = TGT_REG;
      lat     = (addr[19:16] == 4'h0) ? CW'(REG_FAST_LAT) : CW'(REG_LAT);
    end else if (addr < 32'h0600_0000) begin
      res.tgt = TGT_STUB;
    end else if (addr < 32'h0800_0000) begin
      res.tgt = TGT_EXT;
      res.dom = DOM_ONE;
      lat     = CW'(DOM1_LAT);
    end else if (addr < 32'h1000_0000) begin
      res.tgt = TGT_EXT;
      res.dom = DOM_TWO;
      lat     = CW'(DOM2_LAT);
    end else if (addr < 32'h1FC0_0000) begin
      res.tgt = TGT_EXT;
      res.dom = DOM_ONE;
      lat     = CW'(DOM1_LAT);
    end else if (addr < 32'h1FD0_0000) begin
      res.tgt = TGT_STUB;
    end else begin
      res.tgt = TGT_EXT;
      res.dom = DOM_ONE;
      lat     = CW'(DOM1_LAT);
    end
    res.neverDone = (res.tgt == TGT_IGNORE)
                 || (cached && res.tgt != TGT_RAM)
                 || (!write && size == SIZE_64 &&
                     (res.tgt == TGT_REG || res.tgt == TGT_EXT));
  end
endmodule

// File: rtl/sysbus_dpath.sv
`timescale 1ns/1ps
module sysbus_dpath
  import sysbus_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  decodeRes_t    res,
  input  logic [CW-1:0] lat,
  input  logic [31:0]   addr,
  input  logic          write,
  output target_e       tgtQ,
  output domain_e       domQ,
  output logic          cntZero,
  output logic [63:0]   dataQ
);
  logic [CW-1:0] cntQ;
  logic [63:0]   dataNext;

  always_comb begin
    dataNext = '0;
    if (!write) begin
      unique case (res.tgt)
        TGT_RAM: dataNext = {~addr, addr};
        TGT_REG: dataNext = {32'h0, addr[31:2], 2'b00};
        TGT_EXT: dataNext = {32'h0, addr[15:0], addr[15:0]};
        default: dataNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtQ  <= TGT_NONE;
      domQ  <= DOM_NONE;
      cntQ  <= '0;
      dataQ <= '0;
    end else if (strobe.load) begin
      tgtQ  <= res.tgt;
      domQ  <= res.dom;
      cntQ  <= lat - CW'(1);
      dataQ <= dataNext;
    end else if (strobe.tick && cntQ != '0) begin
      cntQ  <= cntQ - CW'(1);
    end
  end

  assign cntZero = (cntQ == '0);

  // R4: a timing configuration is only reported for the external bus
  p_dom_ext_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (domQ != DOM_NONE) |-> (tgtQ == TGT_EXT));
endmodule

// File: rtl/sysbus_ctrl.sv
`timescale 1ns/1ps
module sysbus_ctrl
  import sysbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        neverDone,
  input  logic        cntZero,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        rspValid,
  output logic        hung
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_HUNG} state_e;
  state_e stateQ, stateNext;
  logic accept;

  assign accept   = (stateQ == ST_IDLE) && reqValid;
  assign reqReady = (stateQ == ST_IDLE);
  assign rspValid = (stateQ == ST_BUSY) && cntZero;
  assign hung     = (stateQ == ST_HUNG);

  always_comb begin
    strobe.load = accept;
    strobe.tick = (stateQ == ST_BUSY);
    stateNext   = stateQ;
    unique case (stateQ)
      ST_IDLE: if (accept) stateNext = neverDone ? ST_HUNG : ST_BUSY;
      ST_BUSY: if (cntZero) stateNext = ST_IDLE;
      default: stateNext = ST_HUNG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  // R9: a parked router stays parked until reset
  p_hung_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    hung |=> hung);
  // R5: a parked router never completes nor accepts
  p_hung_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    hung |-> (!rspValid && !reqReady));
  // R9: acceptance closes the door for the next cycle
  p_single_outstanding_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  // R9: completion reopens acceptance
  p_reopen_after_rsp_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);
endmodule

// File: rtl/sysbus_router.sv
`timescale 1ns/1ps
module sysbus_router
  import sysbus_pkg::*;
#(
  parameter int unsigned RAM_LAT      = 4,
  parameter int unsigned REG_LAT      = 5,
  parameter int unsigned REG_FAST_LAT = 2,
  parameter int unsigned DOM1_LAT     = 6,
  parameter int unsigned DOM2_LAT     = 10,
  parameter int unsigned STUB_LAT     = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic        reqCached,
  output logic        rspValid,
  output logic [63:0] rspData,
  output logic [2:0]  tgtSel,
  output logic [1:0]  domSel,
  output logic        hung
);
  localparam int unsigned MAX_A = (RAM_LAT > REG_LAT) ? RAM_LAT : REG_LAT;
  localparam int unsigned MAX_B = (DOM1_LAT > DOM2_LAT) ? DOM1_LAT : DOM2_LAT;
  localparam int unsigned MAX_C = (REG_FAST_LAT > STUB_LAT) ? REG_FAST_LAT : STUB_LAT;
  localparam int unsigned MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_LAT = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int unsigned CW = $clog2(MAX_LAT + 1);

  decodeRes_t    res;
  logic [CW-1:0] lat;
  ctrlStrobe_t   strobe;
  target_e       tgtQ;
  domain_e       domQ;
  logic          cntZero;
  logic [63:0]   dataQ;

  sysbus_decode #(
    .RAM_LAT(RAM_LAT), .REG_LAT(REG_LAT), .REG_FAST_LAT(REG_FAST_LAT),
    .DOM1_LAT(DOM1_LAT), .DOM2_LAT(DOM2_LAT), .STUB_LAT(STUB_LAT), .CW(CW)
  ) i_decode (
    .addr(reqAddr), .write(reqWrite), .size(reqSize), .cached(reqCached),
    .res(res), .lat(lat)
  );

  sysbus_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .neverDone(res.neverDone),
    .cntZero(cntZero), .strobe(strobe), .reqReady(reqReady),
    .rspValid(rspValid), .hung(hung)
  );

  sysbus_dpath #(.CW(CW)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .res(res), .lat(lat),
    .addr(reqAddr), .write(reqWrite), .tgtQ(tgtQ), .domQ(domQ),
    .cntZero(cntZero), .dataQ(dataQ)
  );

  assign tgtSel  = tgtQ;
  assign domSel  = domQ;
  assign rspData = rspValid ? dataQ : 64'h0;

  // R5: high addresses always park the router on the ignored target
  p_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqAddr[31]) |=> (hung && tgtSel == 3'd5));
  // R6: cached requests outside RAM park the router
  p_cached_hang_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqCached && reqAddr >= 32'h03F0_0000) |=> hung);
  // R1: RAM requests never park the router
  p_ram_live_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqAddr < 32'h03F0_0000) |=> (!hung && tgtSel == 3'd1));
endmodule

// File: tb/test_sysbus_router.sv
`timescale 1ns/1ps
module test_sysbus_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic        reqCached = 1'b0;
  logic        rspValid;
  logic [63:0] rspData;
  logic [2:0]  tgtSel;
  logic [1:0]  domSel;
  logic        hung;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sysbus_router i_sysbus_router (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqCached(reqCached), .rspValid(rspValid), .rspData(rspData),
    .tgtSel(tgtSel), .domSel(domSel), .hung(hung)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive at a negedge, accepted at the next posedge
  task automatic issue(input logic [31:0] a, input logic w, input logic [1:0] s, input logic c);
    @(negedge clk);
    reqAddr = a; reqWrite = w; reqSize = s; reqCached = c; reqValid = 1'b1;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic expectDone(input string tag, input int expLat, input logic [63:0] expData,
                            input int expTgt, input int expDom);
    int n = 1;
    @(negedge clk);
    while (!rspValid && n < 64) begin @(negedge clk); n++; end
    check({tag, " latency"}, 64'(n), 64'(expLat));
    check({tag, " data"}, rspData, expData);
    check({tag, " tgtSel"}, 64'(tgtSel), 64'(expTgt));
    check({tag, " domSel"}, 64'(domSel), 64'(expDom));
    @(negedge clk);
    check({tag, " ready after"}, 64'(reqReady), 64'd1);
  endtask

  task automatic expectHang(input string tag, input int expTgt);
    int rsp = 0;
    int rdy = 0;
    @(negedge clk);
    reqValid = 1'b1;  // keep knocking: must not be accepted
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rspValid) rsp++;
      if (reqReady) rdy++;
    end
    reqValid = 1'b0;
    check({tag, " no reply"}, 64'(rsp), 64'd0);
    check({tag, " R9 never ready"}, 64'(rdy), 64'd0);
    check({tag, " hung"}, 64'(hung), 64'd1);
    check({tag, " tgtSel"}, 64'(tgtSel), 64'(expTgt));
    doReset();
    @(negedge clk);
    check({tag, " R9 reset clears hung"}, 64'(hung), 64'd0);
  endtask

  task automatic t_reset();
    doReset();
    @(negedge clk);
    check("R10 reqReady", 64'(reqReady), 64'd1);
    check("R10 rspValid", 64'(rspValid), 64'd0);
    check("R10 tgtSel", 64'(tgtSel), 64'd0);
    check("R10 domSel", 64'(domSel), 64'd0);
    check("R10 hung", 64'(hung), 64'd0);
  endtask

  task automatic t_ram();
    logic [31:0] a = 32'h0010_0008;
    issue(a, 1'b0, 2'd3, 1'b0);
    #2 check("R9 busy not ready", 64'(reqReady), 64'd0);
    expectDone("R1 ram 64b read", 4, {~a, a}, 1, 0);
    a = 32'h03EF_FFFF;
    issue(a, 1'b0, 2'd0, 1'b0);
    expectDone("R1 ram top byte read", 4, {~a, a}, 1, 0);
    issue(32'h0000_0100, 1'b1, 2'd3, 1'b0);
    expectDone("R1 ram write", 4, 64'h0, 1, 0);
    a = 32'h0200_0040;
    issue(a, 1'b0, 2'd2, 1'b1);
    expectDone("R6 cached ram read", 4, {~a, a}, 1, 0);
  endtask

  task automatic t_reg();
    issue(32'h03F4_0006, 1'b0, 2'd0, 1'b0);
    expectDone("R2 reg byte read", 5, 64'h0000_0000_03F4_0004, 2, 0);
    issue(32'h03F0_0012, 1'b0, 2'd1, 1'b0);
    expectDone("R2 reg fast group", 2, 64'h0000_0000_03F0_0010, 2, 0);
    issue(32'h03FF_FFFC, 1'b0, 2'd2, 1'b0);
    expectDone("R2 reg top word", 5, 64'h0000_0000_03FF_FFFC, 2, 0);
    issue(32'h03F8_0000, 1'b1, 2'd3, 1'b0);
    expectDone("R7 reg 64b write", 5, 64'h0, 2, 0);
  endtask

  task automatic t_dom1();
    issue(32'h1000_1234, 1'b0, 2'd2, 1'b0);
    expectDone("R3 rom read", 6, 64'h0000_0000_1234_1234, 3, 1);
    issue(32'h0600_0000, 1'b0, 2'd1, 1'b0);
    expectDone("R3 low window", 6, 64'h0, 3, 1);
    issue(32'h1FD0_ABCD, 1'b0, 2'd0, 1'b0);
    expectDone("R3 upper window", 6, 64'h0000_0000_ABCD_ABCD, 3, 1);
    issue(32'h7FFF_FFFC, 1'b1, 2'd3, 1'b0);
    expectDone("R3 top write 64b", 6, 64'h0, 3, 1);
  endtask

  task automatic t_dom2();
    issue(32'h0800_0000, 1'b0, 2'd2, 1'b0);
    expectDone("R4 slow low", 10, 64'h0, 3, 2);
    issue(32'h0FFF_5A5A, 1'b0, 2'd1, 1'b0);
    expectDone("R4 slow high", 10, 64'h0000_0000_5A5A_5A5A, 3, 2);
  endtask

  task automatic t_stub();
    issue(32'h0400_0000, 1'b0, 2'd2, 1'b0);
    expectDone("R8 stub low", 2, 64'h0, 4, 0);
    issue(32'h05FF_FFF8, 1'b0, 2'd3, 1'b0);
    expectDone("R8 stub 64b read", 2, 64'h0, 4, 0);
    issue(32'h1FC0_0000, 1'b0, 2'd2, 1'b0);
    expectDone("R8 stub gap", 2, 64'h0, 4, 0);
  endtask

  task automatic t_hang();
    issue(32'h8000_0000, 1'b0, 2'd2, 1'b0);
    expectHang("R5 ignored low", 5);
    issue(32'hFFFF_FFFC, 1'b1, 2'd2, 1'b0);
    expectHang("R5 ignored top", 5);
    issue(32'h1000_0000, 1'b0, 2'd2, 1'b1);
    expectHang("R6 cached ext", 3);
    issue(32'h03F4_0000, 1'b0, 2'd2, 1'b1);
    expectHang("R6 cached reg", 2);
    issue(32'h03F0_0000, 1'b0, 2'd3, 1'b0);
    expectHang("R7 reg 64b read", 2);
    issue(32'h0800_0000, 1'b0, 2'd3, 1'b0);
    expectHang("R7 ext 64b read", 3);
  endtask

  initial begin
    t_reset();
    t_ram();
    t_reg();
    t_dom1();
    t_dom2();
    t_stub();
    t_hang();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule